// File: doc/BRIEF.md
# RTC Register Unlock Controller

This block guards the register file of a real-time clock with two separate password mechanisms on a simple register bus. The bus has an address, write data, a write strobe and combinational read data. After power-up the clock is held in a dormant reset state. A single write of a 32-bit initiation word releases it into the active state, and it stays there until the next reset.

The second mechanism is a timed access window. Writing a 16-bit password into the low half of the access register raises an enable flag. The flag drops by itself after a fixed number of RTC clock cycles. Writing the password again while the window is open restarts the count.

The rest of the register file uses the `wr_allowed` qualifier that this block produces. A write to any protected register takes effect only while the clock is active and the window is open. The initiation and access registers are always writable. Time and calendar counting are outside this block, and the whole block runs on a single RTC clock.

Top module: `rtc_pwd_unlock`

## Requirements
- R1: After a synchronous reset, `rtc_active` and `access_en` are 0, and reads at offset 0x0 and offset 0x4 return 0.
- R2: Writing exactly 0xA5EB1357 to offset 0x0 sets `rtc_active` on the next clock. After that, a read of offset 0x0 returns 0x00000001.
- R3: A write of any other value to offset 0x0 leaves `rtc_active` unchanged. Once set, `rtc_active` stays 1 until reset, whatever is written afterwards.
- R4: Writing 0xA965 into bits [15:0] of offset 0x4 sets `access_en` on the next clock. The flag reads back at bit 16 of offset 0x4.
- R5: `access_en` stays 1 for exactly WIN_CYCLES clocks after the password write (default 1024) and is 0 on the following clock.
- R6: Bits [15:0] of a read at offset 0x4 are always 0. All bits of that read other than bit 16 are also always 0.
- R7: A correct password written while the window is open restarts the window. The flag then stays 1 for WIN_CYCLES clocks counted from the latest correct write.
- R8: A write to offset 0x4 whose bits [15:0] differ from 0xA965 changes neither `access_en` nor the remaining window length.
- R9: For a write strobe at any offset other than 0x0 and 0x4, `wr_allowed` is 1 only when both `rtc_active` and `access_en` are 1. `wr_allowed` is always 0 when there is no write strobe.
- R10: A write strobe at offset 0x0 or offset 0x4 always gives `wr_allowed` = 1, whatever the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (6) | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_rdata | output | 32 | Combinational read data for offsets 0x0 and 0x4, zero elsewhere |
| rtc_active | output | 1 | Clock has left the reset state |
| access_en | output | 1 | Access window is open |
| wr_allowed | output | 1 | Current write may update its target register |

## Verification
The bench builds the block with its default parameters: a 1024-cycle window and a 6-bit address. With those values, several complete windows, their exact expiry edge and restarts close to expiry all fit inside a few thousand cycles. Directed cases cover the following:
- reads in the reset state;
- near-miss initiation and password values;
- the last open cycle and the first closed cycle of a window;
- wrong passwords written late in a window.

A seeded random phase then mixes correct and wrong words across all offsets. In that phase the bench checks the flags, the read data and the write qualifier every cycle against a model built on the cycle of the latest unlock.

// File: rtl/rtc_pwd_pkg.sv
// Shared constants for the RTC unlock controller: register offsets and
// the two magic values. Assumes byte addressing of 32-bit registers.
package rtc_pwd_pkg;
    localparam logic [31:0] INIT_WORD = 32'hA5EB_1357;
    localparam logic [15:0] ACC_PWD   = 16'hA965;
    localparam int unsigned OFS_INIT  = 'h0;
    localparam int unsigned OFS_ACC   = 'h4;
endpackage

// File: rtl/rtc_init_latch.sv
// One-shot release latch. Sets when the initiation word is written to its
// register and never clears except by reset. Assumes sel_init is a decoded
// write-strobe-qualified hit on the initiation offset.
module rtc_init_latch
    import rtc_pwd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_init,
    input  logic [31:0] wdata,
    output logic        active
);
    // Latch the active state on the magic word; sticky until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= 1'b0;
        else if (sel_init && (wdata == INIT_WORD))
            active <= 1'b1;
    end

    // R3
    active_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> active);
    // R2
    active_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(sel_init && (wdata == INIT_WORD)));
endmodule

// File: rtl/rtc_access_window.sv
// Self-expiring access window. A correct password opens (or reopens) the
// window for exactly WIN_CYCLES clocks; wrong values are ignored. Assumes
// sel_acc is a write-strobe-qualified hit on the access offset.
module rtc_access_window
    import rtc_pwd_pkg::*;
#(
    parameter int unsigned WIN_CYCLES = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_acc,
    input  logic [15:0] pwd,
    output logic        en
);
    localparam int unsigned CNT_W = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             unlock;
    logic             term;

    // Decode a correct password write and the terminal count.
    always_comb begin
        unlock = sel_acc && (pwd == ACC_PWD);
        term   = en && (cnt == LAST);
    end

    // Open/restart on unlock, count while open, close at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= 1'b0;
            cnt <= '0;
        end else if (unlock) begin
            en  <= 1'b1;
            cnt <= '0;
        end else if (term) begin
            en  <= 1'b0;
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5
    window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !unlock) |=> !en);
    // R4
    window_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> $past(sel_acc && (pwd == ACC_PWD)));
    // R8
    wrong_pwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !term && sel_acc && (pwd != ACC_PWD)) |=> (en && (cnt == $past(cnt) + 1'b1)));
    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unlock |=> (en && (cnt == '0)));
endmodule

// File: rtl/rtc_wr_qualify.sv
// Write qualifier for the downstream register file. The two password
// registers are always writable; every other offset needs an active clock
// and an open access window.
module rtc_wr_qualify (
    input  logic we,
    input  logic hit_open,
    input  logic active,
    input  logic en,
    output logic allowed
);
    // Combine strobe, address class and unlock state.
    always_comb begin
        allowed = we && (hit_open || (active && en));
    end

    // R9
    protect_chk: assert final (!(allowed && !hit_open) || (active && en));
    // R10
    open_reg_chk: assert final (!(we && hit_open) || allowed);
endmodule

// File: rtl/rtc_pwd_unlock.sv
// RTC unlock controller top. Decodes the bus address, drives the release
// latch and the access window, returns status on reads of the two password
// registers, and qualifies writes for the rest of the register file.
// Assumes one bus access per RTC clock and a single clock domain.
module rtc_pwd_unlock
    import rtc_pwd_pkg::*;
#(
    parameter int unsigned ADDR_W     = 6,
    parameter int unsigned WIN_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    output logic              rtc_active,
    output logic              access_en,
    output logic              wr_allowed
);
    localparam logic [ADDR_W-1:0] A_INIT = ADDR_W'(OFS_INIT);
    localparam logic [ADDR_W-1:0] A_ACC  = ADDR_W'(OFS_ACC);

    logic hit_init, hit_acc;

    // Address decode for the two always-open registers.
    always_comb begin
        hit_init = (bus_addr == A_INIT);
        hit_acc  = (bus_addr == A_ACC);
    end

    rtc_init_latch u_init (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_init (bus_we && hit_init),
        .wdata    (bus_wdata),
        .active   (rtc_active)
    );

    rtc_access_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_acc (bus_we && hit_acc),
        .pwd     (bus_wdata[15:0]),
        .en      (access_en)
    );

    rtc_wr_qualify u_qual (
        .we       (bus_we),
        .hit_open (hit_init || hit_acc),
        .active   (rtc_active),
        .en       (access_en),
        .allowed  (wr_allowed)
    );

    // Read mux: status bit 0 at the initiation offset, flag at bit 16 of
    // the access offset with the password field reading zero.
    always_comb begin
        bus_rdata = '0;
        if (hit_init)
            bus_rdata[0] = rtc_active;
        else if (hit_acc)
            bus_rdata[16] = access_en;
    end

    // R6
    pwd_field_zero_chk: assert final (!hit_acc || (bus_rdata[15:0] == 16'h0));
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!rtc_active && !access_en));
endmodule

// File: tb/tb_rtc_pwd_unlock.sv
module tb_rtc_pwd_unlock;
    localparam int WIN = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        rtc_active, access_en, wr_allowed;

    int checks = 0, fails = 0;
    int cyc = 0;            // posedges since reset release
    bit m_act = 0;
    bit m_unl = 0;          // any unlock seen
    int last_unl = 0;       // cyc value right after unlock edge

    always #5 clk = ~clk;

    rtc_pwd_unlock dut (.*);

    function automatic bit exp_en();
        return m_unl && ((cyc - last_unl) < WIN);
    endfunction

    function automatic bit exp_allow(bit we, logic [5:0] a);
        if (!we) return 0;
        if (a == 6'h0 || a == 6'h4) return 1;
        return m_act && exp_en();
    endfunction

    function automatic logic [31:0] exp_rd(logic [5:0] a);
        if (a == 6'h0) return {31'b0, m_act};
        if (a == 6'h4) return {15'b0, exp_en(), 16'b0};
        return 32'h0;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cyc %0d", req, act, exp, cyc);
        end
    endtask

    // Drive one bus cycle at the negedge, check combinational outputs,
    // then advance the model across the posedge and check the flags.
    task automatic step(bit we, logic [5:0] a, logic [31:0] d, string req);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        chk({req, " rdata"}, bus_rdata, exp_rd(a));
        chk("R9/R10 wr_allowed", {31'b0, wr_allowed}, {31'b0, exp_allow(we, a)});
        @(posedge clk);
        cyc++;
        if (we && a == 6'h0 && d == 32'hA5EB1357) m_act = 1;
        if (we && a == 6'h4 && d[15:0] == 16'hA965) begin m_unl = 1; last_unl = cyc; end
        #1;
        chk("R2/R3 active", {31'b0, rtc_active}, {31'b0, m_act});
        chk({req, " access_en"}, {31'b0, access_en}, {31'b0, exp_en()});
    endtask

    task automatic idle(int n, string req);
        for (int i = 0; i < n; i++) step(0, 6'h8, 32'h0, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        step(0, 6'h0, 0, "R1");
        step(0, 6'h4, 0, "R1");
        // R9 protected write before anything
        step(1, 6'hC, 32'h1234, "R9");
        // R4 password before activation opens window, R9 still blocked
        step(1, 6'h4, 32'hFFFF_A965, "R4");
        step(1, 6'h10, 32'h1, "R9");
        // R3 near-miss init word
        step(1, 6'h0, 32'hA5EB1356, "R3");
        step(1, 6'h0, 32'hA5EB1357, "R2");
        step(1, 6'h14, 32'h1, "R9");
        step(0, 6'h4, 0, "R6");
        // R5 run to the exact expiry edge
        idle(WIN - 6, "R5");
        step(0, 6'h4, 0, "R5 last open");
        step(0, 6'h4, 0, "R5 closed");
        step(1, 6'h1C, 32'h5, "R9 closed");
        // R8 wrong passwords late in a window
        step(1, 6'h4, 32'h0000_A965, "R4");
        idle(WIN - 10, "R8");
        step(1, 6'h4, 32'h0000_A964, "R8");
        step(1, 6'h4, 32'hA965_0000, "R8");
        idle(5, "R8");
        // R7 restart close to expiry
        step(1, 6'h4, 32'h0000_A965, "R4");
        idle(WIN - 3, "R7");
        step(1, 6'h4, 32'h1234_A965, "R7");
        idle(WIN + 2, "R7");
        // R3 writes cannot deactivate
        step(1, 6'h0, 32'h0, "R3");
        // random phase
        for (int i = 0; i < 6000; i++) begin
            logic [5:0] a;
            logic [31:0] d;
            bit we;
            int r;
            r = $urandom_range(0, 99);
            a = (r < 40) ? 6'h4 : (r < 50) ? 6'h0 : 6'(4 * $urandom_range(2, 12));
            we = ($urandom_range(0, 3) != 0);
            d = $urandom;
            if ($urandom_range(0, 60) == 0) d[15:0] = 16'hA965;
            step(we, a, d, "R8 random");
        end
        // R1 reset again returns to dormant state
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1 active", {31'b0, rtc_active}, 32'h0);
        chk("R1 access_en", {31'b0, access_en}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        m_act = 0; m_unl = 0; cyc = 0;
        step(0, 6'h0, 0, "R1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule